// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

This block counts time in two stages. A 6-bit prescaler divides the count enable by a programmable ratio and pulses once per period. Each pulse decrements an 8-bit down-counter. When the counter steps down from one, an end-of-count event occurs. That event sets a sticky interrupt flag and flips a toggle output. Depending on the mode, the counter then either reloads and keeps running or stops at zero.

Software drives the block through a small register bus. Writes take effect at the clock edge, and reads are combinational, so the live count can be read at any time without any side effect. A single external input pin, after a two-stage synchronizer, can be used in one of three ways: as the count clock (its rising edges), as a level gate, or as a trigger that arms and restarts the count. One output pin shows either the toggle output or the system clock.

Register offsets:
- 0: reload value, 8 bits.
- 1: prescale value, bits 5:0.
- 2: control.
- 3: live count, read only.

Control bits:
- bit 0: load strobe (write 1; always reads 0).
- bit 1: run.
- bit 2: continuous.
- bits 4:3: input mode (00 internal, 01 external clock, 10 gate, 11 trigger).
- bit 5: output select.
- bit 6: interrupt mask.
- bit 7: interrupt flag on read; writing 1 clears it.

Top module: `pscl_down_timer`

## Requirements
- R1: After reset, all four registers read 0, irq is 0 and tmr_out is 0.
- R2: While counting is enabled, the count decrements once every N enabled cycles. N is the prescale value for 1..63, and a prescale value of 0 means N = 64.
- R3: Writing control with bit 0 set copies the reload value into the count and restarts the prescale period. Control bit 0 always reads 0.
- R4: With control bit 1 (run) clear, the count holds its value.
- R5: Each end of count (the count stepping down from 1) inverts the toggle output.
- R6: With control bit 2 clear, an end of count leaves the count at 0 and clears the run bit.
- R7: With control bit 2 set, an end of count reloads the count from the reload register. A reload value of 0 gives 256 steps.
- R8: An end of count sets the flag (control bit 7). The flag holds until a control write with bit 7 set, and a same-cycle end of count wins over the clear. irq equals the flag AND the mask (control bit 6).
- R9: Reading any register at any time returns the current state and does not disturb the count.
- R10: In input mode 01, the count advances only on synchronized rising edges of ext_in.
- R11: In input mode 10, counting proceeds only while the synchronized ext_in is high.
- R12: In input mode 11, no counting occurs until a synchronized rising edge of ext_in. Every such edge reloads the count and the prescaler and arms counting. A load strobe disarms it.
- R13: With control bit 5 set, tmr_out follows clk; with it clear, tmr_out shows the toggle output.
- R14: Writes to offset 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| ext_in | input | 1 | External clock, gate or trigger input |
| tmr_out | output | 1 | Toggle output or system clock |
| irq | output | 1 | Masked end-of-count interrupt request |

## Verification
The hardest case is the retrigger in input mode 11. It requires a rising edge to arrive while the counter is mid-period with a partly used prescale count. The edge must also be visible only after two synchronizer stages and one edge-detect stage. The stimulus arms the counter with one pulse, lets it run a known number of cycles to a count that differs from the reload value, and then sends a second pulse timed so that the reload lands three edges later. A behavioural model in the bench tracks the synchronizer delay with its own history variables and compares the read data, irq and tmr_out on every clock.

// File: rtl/pscl_down_timer.sv
module pscl_down_timer #(
  parameter int PRE_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ext_in,
  output logic       tmr_out,
  output logic       irq
);
  localparam logic [1:0] M_INT = 2'd0, M_CLK = 2'd1, M_GATE = 2'd2, M_TRIG = 2'd3;

  logic [2:0]       sync_q;
  logic [7:0]       reload_q, cnt_q;
  logic [PRE_W-1:0] pres_q, pre_q;
  logic [1:0]       mode_q;
  logic             run_q, cont_q, osel_q, mask_q, flag_q, tog_q, armed_q;

  wire ext_lvl  = sync_q[1];
  wire ext_rise = sync_q[1] & ~sync_q[2];
  wire wr_ctl   = bus_wr && bus_addr == 2'd2;
  wire ld       = wr_ctl && bus_wdata[0];
  wire retrig   = mode_q == M_TRIG && ext_rise;

  logic en_src;
  always_comb begin
    case (mode_q)
      M_INT:   en_src = 1'b1;
      M_CLK:   en_src = ext_rise;
      M_GATE:  en_src = ext_lvl;
      default: en_src = armed_q;
    endcase
  end

  wire tick   = run_q && !ld && !retrig && en_src;
  wire pre_tc = tick && pre_q == PRE_W'(1);
  wire eoc    = pre_tc && cnt_q == 8'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      reload_q <= '0;
      pres_q   <= '0;
      {mask_q, osel_q, mode_q, cont_q, run_q} <= '0;
      flag_q   <= 1'b0;
      tog_q    <= 1'b0;
      cnt_q    <= '0;
      pre_q    <= '0;
      armed_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], ext_in};
      if (bus_wr && bus_addr == 2'd0) reload_q <= bus_wdata;
      if (bus_wr && bus_addr == 2'd1) pres_q <= bus_wdata[PRE_W-1:0];
      if (wr_ctl) {mask_q, osel_q, mode_q, cont_q, run_q} <= bus_wdata[6:1];
      else if (eoc && !cont_q) run_q <= 1'b0;
      if (eoc) flag_q <= 1'b1;
      else if (wr_ctl && bus_wdata[7]) flag_q <= 1'b0;
      if (eoc) tog_q <= ~tog_q;
      if (ld || retrig) begin
        cnt_q <= reload_q;
        pre_q <= pres_q;
      end else if (tick) begin
        pre_q <= pre_tc ? pres_q : pre_q - 1'b1;
        if (pre_tc) cnt_q <= eoc ? (cont_q ? reload_q : 8'd0) : cnt_q - 8'd1;
      end
      if (ld) armed_q <= 1'b0;
      else if (retrig) armed_q <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = reload_q;
      2'd1:    bus_rdata = 8'(pres_q);
      2'd2:    bus_rdata = {flag_q, mask_q, osel_q, mode_q, cont_q, run_q, 1'b0};
      default: bus_rdata = cnt_q;
    endcase
  end

  assign irq     = flag_q & mask_q;
  assign tmr_out = osel_q ? clk : tog_q;

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt_q == $past(reload_q)); // R3
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !ld && !retrig |=> $stable(cnt_q)); // R4
  AST_EOC_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> tog_q != $past(tog_q)); // R5
  AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    eoc && !cont_q && !wr_ctl |=> !run_q && cnt_q == 8'd0); // R6
  AST_CONT_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    eoc && cont_q |=> cnt_q == $past(reload_q)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !(wr_ctl && bus_wdata[7]) |=> flag_q); // R8
  AST_GATE_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == M_GATE && !ext_lvl && !ld |=> $stable(cnt_q) && $stable(pre_q)); // R11
endmodule

// File: tb/pscl_down_timer_tb_top.sv
module pscl_down_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, ext_in = 1'b0;
  logic [1:0] bus_addr = 2'd3;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic tmr_out, irq;
  int checks = 0, fails = 0;

  pscl_down_timer dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in), .tmr_out(tmr_out), .irq(irq));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_reload = 0, m_pres = 0, m_mode = 0, m_cnt = 0, m_left = 64;
  bit m_run = 0, m_cont = 0, m_osel = 0, m_mask = 0, m_flag = 0, m_tog = 0, m_armed = 0;
  bit e1 = 0, e2 = 0, e3 = 0;
  bit rise, lvl, ld, rt, en, eoc, n_run;

  function automatic int divisor(int p);
    return (p == 0) ? 64 : p;
  endfunction

  function automatic int mread(int a);
    case (a)
      0: return m_reload;
      1: return m_pres;
      2: return m_flag * 128 + m_mask * 64 + m_osel * 32 + m_mode * 8 + m_cont * 4 + m_run * 2;
      default: return m_cnt;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reload = 0; m_pres = 0; m_mode = 0; m_cnt = 0; m_left = 64;
      m_run = 0; m_cont = 0; m_osel = 0; m_mask = 0; m_flag = 0; m_tog = 0; m_armed = 0;
      e1 = 0; e2 = 0; e3 = 0;
    end else begin
      rise = e2 && !e3;
      lvl = e2;
      ld = bus_wr && bus_addr == 2 && bus_wdata[0];
      rt = (m_mode == 3) && rise;
      en = m_run && !ld && !rt && (m_mode == 0 || (m_mode == 1 && rise) ||
           (m_mode == 2 && lvl) || (m_mode == 3 && m_armed));
      eoc = 0;
      n_run = m_run;
      if (ld || rt) begin
        m_cnt = m_reload;
        m_left = divisor(m_pres);
      end else if (en) begin
        m_left--;
        if (m_left == 0) begin
          m_left = divisor(m_pres);
          if (m_cnt == 1) begin
            eoc = 1;
            if (m_cont) m_cnt = m_reload;
            else begin m_cnt = 0; n_run = 0; end
          end else m_cnt = (m_cnt + 255) % 256;
        end
      end
      if (ld) m_armed = 0; else if (rt) m_armed = 1;
      if (eoc) begin m_flag = 1; m_tog = !m_tog; end
      else if (bus_wr && bus_addr == 2 && bus_wdata[7]) m_flag = 0;
      if (bus_wr && bus_addr == 0) m_reload = bus_wdata;
      if (bus_wr && bus_addr == 1) m_pres = bus_wdata[5:0];
      if (bus_wr && bus_addr == 2) begin
        m_run = bus_wdata[1]; m_cont = bus_wdata[2]; m_mode = bus_wdata[4:3];
        m_osel = bus_wdata[5]; m_mask = bus_wdata[6];
      end else m_run = n_run;
      e3 = e2; e2 = e1; e1 = ext_in;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R9 read data", bus_rdata, mread(bus_addr));
    chk("R8 irq", irq, m_flag && m_mask);
    chk("R13 out low phase", tmr_out, m_osel ? 0 : m_tog);
  end

  always @(posedge clk) begin
    #5;
    if (rst_n) chk("R13 out high phase", tmr_out, m_osel ? 1 : m_tog);
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
    bus_addr = 2'd3;
  endtask

  task automatic pulse();
    ext_in = 1'b1; idle(2); ext_in = 1'b0; idle(2);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    rd(0, 0, "R1 reload"); rd(1, 0, "R1 prescale"); rd(2, 0, "R1 control"); rd(3, 0, "R1 count");
    chk("R1 irq", irq, 0); chk("R1 out", tmr_out, 0);

    wr(0, 8'd5); wr(1, 8'd3); wr(2, 8'h47);
    rd(3, 5, "R3 load copies reload"); rd(3, 5, "R9 repeated read");
    rd(2, 8'h46, "R3 strobe reads 0");
    idle(3); rd(3, 4, "R2 divide by 3");
    idle(12); rd(3, 5, "R7 continuous reload");
    chk("R8 irq set", irq, 1); chk("R5 toggle out", tmr_out, 1);

    wr(2, 8'h44); rd(3, 5, "R4 stopped");
    idle(10); rd(3, 5, "R4 held");
    wr(3, 8'hAA); rd(3, 5, "R14 count write ignored");
    chk("R8 flag held", irq, 1);
    wr(2, 8'hC4); chk("R8 flag cleared", irq, 0); rd(2, 8'h44, "R8 control after clear");

    wr(0, 8'd2); wr(1, 8'd0); wr(2, 8'h03);
    idle(64); rd(3, 1, "R2 divide by 64");
    idle(64); rd(3, 0, "R6 single pass at zero"); rd(2, 8'h80, "R6 run cleared");
    chk("R8 masked irq", irq, 0);
    idle(5); rd(3, 0, "R6 stays stopped");
    wr(2, 8'h40); chk("R8 unmask", irq, 1);
    wr(2, 8'hC0); chk("R8 clear", irq, 0);

    wr(0, 8'd3); wr(1, 8'd1); wr(2, 8'h4F);
    idle(10); rd(3, 3, "R10 no edges no count");
    pulse(); pulse(); idle(4); rd(3, 1, "R10 two edges");
    pulse(); idle(4); rd(3, 3, "R10 third edge reloads");
    chk("R10 irq", irq, 1);

    wr(0, 8'd10); wr(1, 8'd1); wr(2, 8'h97);
    idle(6); rd(3, 10, "R11 gate low");
    ext_in = 1'b1; idle(4); ext_in = 1'b0; idle(6);
    rd(3, 6, "R11 four gated cycles");

    wr(0, 8'd4); wr(1, 8'd2); wr(2, 8'h1F);
    idle(8); rd(3, 4, "R12 waits for trigger");
    ext_in = 1'b1; idle(2); ext_in = 1'b0; idle(1);
    rd(3, 4, "R12 trigger reload");
    idle(5); rd(3, 2, "R12 counting after trigger");
    ext_in = 1'b1; idle(2); ext_in = 1'b0; idle(1);
    rd(3, 4, "R12 retrigger reload");

    wr(2, 8'h20);
    chk("R13 clock high", tmr_out, 1);
    #10; chk("R13 clock low", tmr_out, 0);
    idle(1);
    wr(2, 8'h00); chk("R13 toggle shown", tmr_out, 1);
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule